// File: doc/BRIEF.md
# Multiplexed 4:2:2 Video Input Demultiplexer

This block is the digital front end of a three-channel video DAC. It takes three 8-bit pixel ports, a pixel clock and an active-low blank. It delivers three DAC code words: Pr or red, Y or green, and Pb or blue. A two-bit format select chooses one of three packings. Full-rate parallel 4:4:4 takes one sample per port on every clock. Two-port 4:2:2 carries luma on the green port and interleaved chroma on the red port. Byte-serial 4:2:2 carries everything on the green port alone.

In the 4:2:2 packings the block rebuilds complete pixels. It keeps each chroma sample and pairs it with the luma samples that share it. It then sends the Pb, Y and Pr of a pixel to the three code outputs on the same clock edge. The chroma phase restarts at the first clock edge after blank is released, so each active period begins with a Pb sample. A fixed pipeline makes the latency a constant that depends only on the packing.

Top module: `vid422_demux`

## Requirements
- R1: The format select is registered on the clock. Codes 2'b00 and 2'b01 select parallel 4:4:4, 2'b10 selects two-port 4:2:2 and 2'b11 selects byte-serial 4:2:2. The two 4:4:4 codes handle data identically.
- R2: In 4:4:4, on every clock, `pix_r`, `pix_g` and `pix_b` go to `code_r`, `code_g` and `code_b`. A sample captured on edge n appears after edge n+7.
- R3: In 4:4:4 the level of `blank_n` has no effect on the codes that reach the outputs.
- R4: In two-port 4:2:2, `pix_g` gives a Y sample on every edge. `pix_r` gives Pb on even phases and Pr on odd phases. A Y captured on edge n reaches `code_g` after edge n+8, and the first chroma sample of the pair leaves on that same edge.
- R5: In byte-serial 4:2:2, `pix_g` carries the sequence Pb, Y, Pr, Y, where phase 0 is Pb. The Pb captured on edge n and its first Y arrive together after edge n+9. The second Y arrives after edge n+11. Each output set is held for two clocks.
- R6: A Pb/Pr pair stays on `code_b`/`code_r` until the next complete pair replaces it. It lasts two clocks in two-port mode and four clocks in byte-serial mode.
- R7: While `blank_n` is low the chroma phase stays at 0. The first sample captured after `blank_n` rises is phase 0 (Pb), even if the previous active period stopped in the middle of a group.
- R8: The Pb, Y and Pr of one pixel change on the same output edge.
- R9: Driving `rst_n` low clears all outputs and pipeline stages to code 0 at once and sets the phase to 0. Release is synchronised to the clock.
- R10: `pix_b` has no effect in the 4:2:2 packings, and `pix_r` has no effect in byte-serial mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Input packing select |
| blank_n | input | 1 | Active-low blank, restarts chroma phase |
| pix_r | input | 8 | Red / Pr port, chroma in two-port mode |
| pix_g | input | 8 | Green / Y port, all samples in byte-serial mode |
| pix_b | input | 8 | Blue / Pb port, 4:4:4 only |
| code_r | output | 8 | Pr / red DAC code |
| code_g | output | 8 | Y / green DAC code |
| code_b | output | 8 | Pb / blue DAC code |

## Verification
The bench builds the block with its default 8-bit sample width and a base latency of 7. This gives 7, 8 and 9 clocks of latency for the three packings. These depths are short enough that each expected pixel can be scheduled on its exact output cycle and the held chroma can be seen on every intermediate cycle. Random 8-bit codes on the used ports, with noise on the unused ones, expose wrong routing between ports. Stopping an active period one sample into a group, and on an odd chroma sample, tests that the phase restarts on Pb.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

  typedef enum logic [1:0] {
    FMT_RGB444  = 2'b00,
    FMT_YC444   = 2'b01,
    FMT_422_DUO = 2'b10,
    FMT_422_SER = 2'b11
  } fmt_e;

  localparam int PHASE_W = 2;

  function automatic logic is_422(input fmt_e f);
    return f[1];
  endfunction

endpackage

// File: rtl/vid422_rst_sync.sv
module vid422_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/vid422_capture.sv
module vid422_capture
  import vid422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         fmt_sel,
  input  logic               blank_n,
  input  logic [DW-1:0]      pix_r,
  input  logic [DW-1:0]      pix_g,
  input  logic [DW-1:0]      pix_b,
  output fmt_e               fmt_q,
  output logic [PHASE_W-1:0] phase_q,
  output logic [DW-1:0]      cap_r,
  output logic [DW-1:0]      cap_g,
  output logic [DW-1:0]      cap_b
);

  logic               act_q;
  logic               act_d;
  logic [PHASE_W-1:0] phase_d;
  fmt_e               fmt_d;

  // Phase of the sample being captured: restarts on the first active
  // sample after blank, advances while active, parked at 0 while blanked.
  always_comb begin
    act_d = blank_n;
    fmt_d = fmt_e'(fmt_sel);
    if (!blank_n) begin
      phase_d = '0;
    end else if (!act_q) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      phase_q <= '0;
      fmt_q   <= FMT_RGB444;
      cap_r   <= '0;
      cap_g   <= '0;
      cap_b   <= '0;
    end else begin
      act_q   <= act_d;
      phase_q <= phase_d;
      fmt_q   <= fmt_d;
      cap_r   <= pix_r;
      cap_g   <= pix_g;
      cap_b   <= pix_b;
    end
  end

endmodule

// File: rtl/vid422_assemble.sv
module vid422_assemble
  import vid422_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fmt_e               fmt_q,
  input  logic [PHASE_W-1:0] phase_q,
  input  logic [DW-1:0]      cap_r,
  input  logic [DW-1:0]      cap_g,
  input  logic [DW-1:0]      cap_b,
  output logic [DW-1:0]      emit_r,
  output logic [DW-1:0]      emit_g,
  output logic [DW-1:0]      emit_b,
  output logic               y_emit,
  output logic               c_upd
);

  logic [DW-1:0] y_prev_q;
  logic [DW-1:0] pb_hold_q, pb_hold_d;
  logic [DW-1:0] pair_pb_q, pair_pb_d;
  logic [DW-1:0] pair_pr_q, pair_pr_d;
  logic [DW-1:0] emit_r_d, emit_g_d, emit_b_d;
  logic [DW-1:0] chroma_in;
  logic          pb_slot;

  // Slot decode per packing
  always_comb begin
    chroma_in = (fmt_q == FMT_422_SER) ? cap_g : cap_r;
    unique case (fmt_q)
      FMT_422_DUO: begin
        y_emit  = 1'b1;
        pb_slot = ~phase_q[0];
        c_upd   = phase_q[0];
      end
      FMT_422_SER: begin
        y_emit  = ~phase_q[0];
        pb_slot = (phase_q == 2'd0);
        c_upd   = (phase_q == 2'd2);
      end
      default: begin
        y_emit  = 1'b1;
        pb_slot = 1'b0;
        c_upd   = 1'b0;
      end
    endcase
  end

  // Next-state of holding registers and the emitted pixel
  always_comb begin
    pb_hold_d = pb_slot ? chroma_in : pb_hold_q;
    pair_pb_d = c_upd ? pb_hold_q : pair_pb_q;
    pair_pr_d = c_upd ? chroma_in : pair_pr_q;
    if (is_422(fmt_q)) begin
      emit_g_d = y_prev_q;
      emit_b_d = c_upd ? pb_hold_q : pair_pb_q;
      emit_r_d = c_upd ? chroma_in : pair_pr_q;
    end else begin
      emit_g_d = cap_g;
      emit_b_d = cap_b;
      emit_r_d = cap_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_prev_q  <= '0;
      pb_hold_q <= '0;
      pair_pb_q <= '0;
      pair_pr_q <= '0;
    end else begin
      y_prev_q  <= cap_g;
      pb_hold_q <= pb_hold_d;
      pair_pb_q <= pair_pb_d;
      pair_pr_q <= pair_pr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_r <= '0;
      emit_g <= '0;
      emit_b <= '0;
    end else if (y_emit) begin
      emit_r <= emit_r_d;
      emit_g <= emit_g_d;
      emit_b <= emit_b_d;
    end
  end

endmodule

// File: rtl/vid422_delay.sv
module vid422_delay #(
  parameter int W      = 24,
  parameter int STAGES = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_body
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/vid422_demux.sv
module vid422_demux
  import vid422_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BASE_LAT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_sel,
  input  logic          blank_n,
  input  logic [DW-1:0] pix_r,
  input  logic [DW-1:0] pix_g,
  input  logic [DW-1:0] pix_b,
  output logic [DW-1:0] code_r,
  output logic [DW-1:0] code_g,
  output logic [DW-1:0] code_b
);

  localparam int TAIL   = BASE_LAT - 1;
  localparam int TRIPLE = 3 * DW;

  logic               rst_n_int;
  fmt_e               fmt_q;
  logic [PHASE_W-1:0] phase_q;
  logic [DW-1:0]      cap_r, cap_g, cap_b;
  logic [DW-1:0]      emit_r, emit_g, emit_b;
  logic               y_emit;
  logic               c_upd;
  logic [TRIPLE-1:0]  tail_out;

  vid422_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vid422_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .fmt_sel (fmt_sel),
    .blank_n (blank_n),
    .pix_r   (pix_r),
    .pix_g   (pix_g),
    .pix_b   (pix_b),
    .fmt_q   (fmt_q),
    .phase_q (phase_q),
    .cap_r   (cap_r),
    .cap_g   (cap_g),
    .cap_b   (cap_b)
  );

  vid422_assemble #(.DW(DW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .fmt_q   (fmt_q),
    .phase_q (phase_q),
    .cap_r   (cap_r),
    .cap_g   (cap_g),
    .cap_b   (cap_b),
    .emit_r  (emit_r),
    .emit_g  (emit_g),
    .emit_b  (emit_b),
    .y_emit  (y_emit),
    .c_upd   (c_upd)
  );

  vid422_delay #(.W(TRIPLE), .STAGES(TAIL)) u_tail (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   ({emit_r, emit_g, emit_b}),
    .dout  (tail_out)
  );

  assign {code_r, code_g, code_b} = tail_out;

endmodule

// File: rtl/vid422_demux_chk.sv
module vid422_demux_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blank_n,
  input logic [1:0]    fmt_q,
  input logic [1:0]    phase_q,
  input logic          c_upd,
  input logic          y_emit,
  input logic [DW-1:0] cap_g,
  input logic [DW-1:0] emit_r,
  input logic [DW-1:0] emit_g,
  input logic [DW-1:0] emit_b,
  input logic [DW-1:0] code_r,
  input logic [DW-1:0] code_g,
  input logic [DW-1:0] code_b
);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (code_r == '0 && code_g == '0 && code_b == '0));

  // R7
  phase_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (phase_q == 2'd0));

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_q[1]) |=> (emit_g == $past(cap_g) && $past(y_emit)));

  // R6
  chroma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q[1] && $past(fmt_q[1]) && !c_upd) |=> $stable({emit_r, emit_b}));

  // R4
  pair_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q[1] && c_upd) |=> (!c_upd || !$stable(fmt_q)));

endmodule

bind vid422_demux vid422_demux_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .blank_n (blank_n),
  .fmt_q   (fmt_q),
  .phase_q (phase_q),
  .c_upd   (c_upd),
  .y_emit  (y_emit),
  .cap_g   (cap_g),
  .emit_r  (emit_r),
  .emit_g  (emit_g),
  .emit_b  (emit_b),
  .code_r  (code_r),
  .code_g  (code_g),
  .code_b  (code_b)
);

// File: tb/vid422_demux_test.sv
module vid422_demux_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int LAT444     = 7;
  localparam int LATDUO     = 8;
  localparam int LATSER     = 9;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    fmt_sel;
  logic          blank_n;
  logic [DW-1:0] pix_r, pix_g, pix_b;
  logic [DW-1:0] code_r, code_g, code_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid422_demux #(.DW(DW), .BASE_LAT(LAT444)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_sel (fmt_sel),
    .blank_n (blank_n),
    .pix_r   (pix_r),
    .pix_g   (pix_g),
    .pix_b   (pix_b),
    .code_r  (code_r),
    .code_g  (code_g),
    .code_b  (code_b)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int              q_cyc[$];
  logic [3*DW-1:0] q_val[$];
  string           q_tag[$];
  int              checks = 0;
  int              fails  = 0;
  bit              done   = 1'b0;

  task automatic report_end();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic expect_at(input int c, input logic [DW-1:0] r, g, b, input string tag);
    q_cyc.push_back(c);
    q_val.push_back({r, g, b});
    q_tag.push_back(tag);
  endtask

  task automatic put(input logic [1:0] f, input logic [DW-1:0] r, g, b,
                     input logic bl, output int cap);
    @(negedge clk);
    fmt_sel = f;
    pix_r   = r;
    pix_g   = g;
    pix_b   = b;
    blank_n = bl;
    cap     = cyc + 1;
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  // Monitor: pops scheduled pixels on their output cycle
  always @(negedge clk) begin
    if (!done) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
        checks++;
        if (q_cyc[0] < cyc) begin
          fails++;
          $display("FAIL %s missed slot cyc=%0d actual=none expected=%h", q_tag[0], q_cyc[0], q_val[0]);
        end else if ({code_r, code_g, code_b} !== q_val[0]) begin
          fails++;
          $display("FAIL %s cyc=%0d actual=%h expected=%h", q_tag[0], cyc,
                   {code_r, code_g, code_b}, q_val[0]);
        end
        void'(q_cyc.pop_front());
        void'(q_val.pop_front());
        void'(q_tag.pop_front());
      end
      if (cyc > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
        report_end();
      end
    end
  end

  initial begin
    int c, ca, cb;
    logic [DW-1:0] r, g, b, pb, pr, y0, y1;
    rst_n   = 1'b0;
    fmt_sel = 2'b00;
    blank_n = 1'b1;
    pix_r   = 8'h5A;
    pix_g   = 8'hA5;
    pix_b   = 8'h3C;
    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is held with non-zero inputs
    checks++;
    if ({code_r, code_g, code_b} !== '0) begin
      fails++;
      $display("FAIL R9 actual=%h expected=%h", {code_r, code_g, code_b}, 24'h0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: parallel 4:4:4, blank high
    for (int i = 0; i < 12; i++) begin
      r = rnd(); g = rnd(); b = rnd();
      put(2'b00, r, g, b, 1'b1, c);
      expect_at(c + LAT444, r, g, b, "R2");
    end
    // R3: blank low has no effect in 4:4:4
    for (int i = 0; i < 5; i++) begin
      r = rnd(); g = rnd(); b = rnd();
      put(2'b00, r, g, b, 1'b0, c);
      expect_at(c + LAT444, r, g, b, "R3");
    end
    // R1: second 4:4:4 code routes identically
    for (int i = 0; i < 6; i++) begin
      r = rnd(); g = rnd(); b = rnd();
      put(2'b01, r, g, b, 1'b1, c);
      expect_at(c + LAT444, r, g, b, "R1");
    end

    // Two-port 4:2:2
    for (int i = 0; i < 10; i++) put(2'b10, rnd(), rnd(), rnd(), 1'b0, c);
    for (int i = 0; i < 6; i++) begin
      pb = rnd(); pr = rnd(); y0 = rnd(); y1 = rnd();
      put(2'b10, pb, y0, rnd(), 1'b1, ca);
      put(2'b10, pr, y1, rnd(), 1'b1, cb);
      expect_at(ca + LATDUO, pr, y0, pb, "R4 R8 R10");
      expect_at(cb + LATDUO, pr, y1, pb, "R6");
    end
    // R7: stop on an odd chroma sample, blank, restart on Pb
    put(2'b10, rnd(), rnd(), rnd(), 1'b1, c);
    for (int i = 0; i < 3; i++) put(2'b10, rnd(), rnd(), rnd(), 1'b0, c);
    for (int i = 0; i < 4; i++) begin
      pb = rnd(); pr = rnd(); y0 = rnd(); y1 = rnd();
      put(2'b10, pb, y0, rnd(), 1'b1, ca);
      put(2'b10, pr, y1, rnd(), 1'b1, cb);
      expect_at(ca + LATDUO, pr, y0, pb, "R7");
      expect_at(cb + LATDUO, pr, y1, pb, "R7");
    end

    // Byte-serial 4:2:2
    for (int i = 0; i < 12; i++) put(2'b11, rnd(), rnd(), rnd(), 1'b0, c);
    for (int i = 0; i < 4; i++) begin
      pb = rnd(); pr = rnd(); y0 = rnd(); y1 = rnd();
      put(2'b11, rnd(), pb, rnd(), 1'b1, ca);
      put(2'b11, rnd(), y0, rnd(), 1'b1, c);
      put(2'b11, rnd(), pr, rnd(), 1'b1, c);
      put(2'b11, rnd(), y1, rnd(), 1'b1, c);
      expect_at(ca + LATSER,     pr, y0, pb, "R5 R10");
      expect_at(ca + LATSER + 1, pr, y0, pb, "R5");
      expect_at(ca + LATSER + 2, pr, y1, pb, "R6");
      expect_at(ca + LATSER + 3, pr, y1, pb, "R6");
    end
    // R7: stop after Pb,Y of a group, blank, restart on Pb
    put(2'b11, rnd(), rnd(), rnd(), 1'b1, c);
    put(2'b11, rnd(), rnd(), rnd(), 1'b1, c);
    for (int i = 0; i < 3; i++) put(2'b11, rnd(), rnd(), rnd(), 1'b0, c);
    for (int i = 0; i < 3; i++) begin
      pb = rnd(); pr = rnd(); y0 = rnd(); y1 = rnd();
      put(2'b11, rnd(), pb, rnd(), 1'b1, ca);
      put(2'b11, rnd(), y0, rnd(), 1'b1, c);
      put(2'b11, rnd(), pr, rnd(), 1'b1, c);
      put(2'b11, rnd(), y1, rnd(), 1'b1, c);
      expect_at(ca + LATSER,     pr, y0, pb, "R7");
      expect_at(ca + LATSER + 2, pr, y1, pb, "R7");
    end
    for (int i = 0; i < 4; i++) put(2'b11, rnd(), rnd(), rnd(), 1'b0, c);

    repeat (20) @(negedge clk);
    if (q_cyc.size() > 0) begin
      checks++;
      fails++;
      $display("FAIL drain actual=%0d expected=0 pending items", q_cyc.size());
    end
    report_end();
  end

endmodule